// File: doc/BRIEF.md
# Error Pin Output Controller

This block drives an active-low error output that tells the outside of the chip a failure has been seen. Safety checkers pulse `fail_i`. The block latches the pulse, pulls the pin low, and loads a low-time counter. The pin cannot return high until two things are true. First, the counter has run down from the most recent failure. Second, software has asked for a release by writing a key into a 4-bit key register.

Software can also prove the pin path by writing a test key. This puts the block into forcing mode, which holds the pin low for as long as the mode lasts. While forcing, a failure is still latched, and the counter is parked at its full preload. Leaving forcing mode then starts the counter, and the pin stays low until the counter runs out and a release is requested. A status bit mirrors the pin level so that software can see whether the pin is high.

Key codes: `0000` is the off key, `0101` is the release key and `1010` is the test key. `LOW_CYCLES` is the counter preload.

Top module: `errpin_ctrl`

## Requirements
- R1: After reset, `pin_n_o` = 1, `pin_ok_o` = 1 and `key_rdata_o` = 0000. A reset in the middle of operation returns the block to this state. `pin_ok_o` always equals `pin_n_o`.
- R2: A failure sampled at a clock edge makes `pin_n_o` = 0 right after that edge.
- R3: Suppose a release is already pending when a failure is sampled at edge E. The pin then goes high right after edge E+LOW_CYCLES+1, and the key register reads back 0000 at that point.
- R4: A new failure while the pin is low reloads the counter. The release is then timed from the latest failure.
- R5: Suppose the counter has expired and no release is pending. The pin stays low. A release key written at edge W raises the pin right after edge W+1.
- R6: Writing the release key `0101` while the pin is high is remembered, and the key register reads 0101 until the release is used.
- R7: Writing the test key `1010` while `pin_ok_o` = 1 enters forcing mode. The pin goes low and the key register reads 1010.
- R8: Writing the test key while the pin is low because of a failure has no effect.
- R9: Writing the off key `0000` in forcing mode, when no failure was latched, returns the pin high right after that write edge.
- R10: A failure during forcing mode holds the counter at its preload. Suppose the off key is written at edge X and a release follows. The pin then goes high right after edge X+LOW_CYCLES+1, however long forcing lasted.
- R11: Some writes are ignored and change neither the key register nor the pin. These are any key other than 0000, 0101 and 1010, and any key other than 0000 while forcing.
- R12: Writing the off key in normal mode cancels a pending release. After that, an expired counter leaves the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fail_i | input | 1 | Failure pulse from the safety checkers |
| key_we_i | input | 1 | Write strobe for the key register |
| key_wdata_i | input | 4 | Key value to be written |
| key_rdata_o | output | 4 | Current key register content |
| pin_n_o | output | 1 | Active-low error pin level |
| pin_ok_o | output | 1 | Pin status, 1 when the pin is high |

## Verification
The release path is tried with three orderings:
- A release request written before the failure tells the remembered request apart from one that is lost.
- A request written after expiry separates the timed release from the keyed release.
- A second failure inside the low window shows whether the counter restarts or keeps its original deadline.

Forcing mode is entered with and without a failure arriving during it. This separates the immediate return from the counted return, and a long stay in forcing mode shows that the counter is parked. Illegal keys, the release key written during forcing, the test key written while the pin is low, and a cancelled release each leave the key readback unchanged, which exposes writes that are wrongly accepted.

// File: rtl/errpin_pkg.sv
package errpin_pkg;

    typedef enum logic [3:0] {
        KEY_OFF   = 4'b0000,
        KEY_REL   = 4'b0101,
        KEY_FORCE = 4'b1010
    } errkey_e;

endpackage

// File: rtl/errpin_keyreg.sv
module errpin_keyreg
    import errpin_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  logic [3:0] wdata_i,
    input  logic       pin_ok_i,
    input  logic       consume_i,
    output logic [3:0] key_o,
    output logic       force_o,
    output logic       rel_o
);

    typedef struct packed {
        errkey_e key;
    } kstate_t;

    kstate_t st_d, st_q;
    logic    accept;

    // decide whether the written key is taken
    always_comb begin
        accept = 1'b0;
        if (we_i) begin
            if (st_q.key == KEY_FORCE) begin
                // in forcing mode only the off key counts
                accept = (wdata_i == KEY_OFF);
            end else begin
                unique case (wdata_i)
                    KEY_OFF:   accept = 1'b1;
                    KEY_REL:   accept = 1'b1;
                    KEY_FORCE: accept = pin_ok_i;
                    default:   accept = 1'b0;
                endcase
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.key = errkey_e'(wdata_i);
        end else if (consume_i) begin
            st_d.key = KEY_OFF;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{key: KEY_OFF};
        else         st_q <= st_d;
    end

    assign key_o   = st_q.key;
    assign force_o = (st_q.key == KEY_FORCE);
    assign rel_o   = (st_q.key == KEY_REL);

    assert_force_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wdata_i == KEY_FORCE && pin_ok_i) |=> force_o);

    assert_bad_key_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wdata_i != KEY_OFF && wdata_i != KEY_REL && wdata_i != KEY_FORCE && !consume_i)
        |=> $stable(key_o));

    assert_force_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_o && !(we_i && wdata_i == KEY_OFF)) |=> force_o);

endmodule

// File: rtl/errpin_ltc.sv
module errpin_ltc #(
    parameter int CNT_W      = 16,
    parameter int LOW_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);

    localparam logic [CNT_W-1:0] PRELOAD = CNT_W'(LOW_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = PRELOAD;
        end else if (run_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: '0};
        else         st_q <= st_d;
    end

    assign expired_o = (st_q.cnt == '0);

    assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !expired_o);

    assert_park_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !run_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/errpin_ctrl.sv
module errpin_ctrl
    import errpin_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LOW_CYCLES = 1000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fail_i,
    input  logic       key_we_i,
    input  logic [3:0] key_wdata_i,
    output logic [3:0] key_rdata_o,
    output logic       pin_n_o,
    output logic       pin_ok_o
);

    typedef struct packed {
        logic fail_lat;
    } pstate_t;

    pstate_t st_d, st_q;
    logic    forcing, rel_pend, expired, release_now, pin_low;

    errpin_keyreg u_keyreg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (key_we_i),
        .wdata_i  (key_wdata_i),
        .pin_ok_i (pin_ok_o),
        .consume_i(release_now),
        .key_o    (key_rdata_o),
        .force_o  (forcing),
        .rel_o    (rel_pend)
    );

    errpin_ltc #(
        .CNT_W     (CNT_W),
        .LOW_CYCLES(LOW_CYCLES)
    ) u_ltc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (fail_i),
        .run_i    (!forcing),
        .expired_o(expired)
    );

    // a release is used only outside forcing, once the low time is over
    always_comb begin
        release_now = st_q.fail_lat && expired && rel_pend && !forcing && !fail_i;
        st_d = st_q;
        if (fail_i)           st_d.fail_lat = 1'b1;
        else if (release_now) st_d.fail_lat = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{fail_lat: 1'b0};
        else         st_q <= st_d;
    end

    assign pin_low  = st_q.fail_lat || forcing;
    assign pin_n_o  = !pin_low;
    assign pin_ok_o = !pin_low;

    assert_fail_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_i |=> !pin_n_o);

    assert_force_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_rdata_o == KEY_FORCE) |-> !pin_n_o);

    assert_rise_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pin_n_o) |-> ($past(key_rdata_o) == KEY_REL || $past(key_rdata_o) == KEY_FORCE));

    assert_low_bad_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pin_ok_o && key_rdata_o != KEY_FORCE && key_we_i && key_wdata_i == KEY_FORCE) |=> key_rdata_o != KEY_FORCE);

endmodule

// File: tb/errpin_ctrl_bench.sv
module errpin_ctrl_bench;

    localparam int L = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fail = 1'b0;
    logic       we = 1'b0;
    logic [3:0] wdata = 4'h0;
    logic [3:0] rdata;
    logic       pin_n, pin_ok;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    errpin_ctrl #(.CNT_W(16), .LOW_CYCLES(L)) u_errpin_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .fail_i     (fail),
        .key_we_i   (we),
        .key_wdata_i(wdata),
        .key_rdata_o(rdata),
        .pin_n_o    (pin_n),
        .pin_ok_o   (pin_ok)
    );

    // [15] we, [14:11] wdata, [10] fail, [9] expected pin, [8:5] expected key, [4:0] requirement
    localparam int NV = 62;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0,4'h0,1'b0,1'b1,4'h0,5'd1},   // R1 idle after reset
        {1'b1,4'h5,1'b0,1'b1,4'h5,5'd6},   // R6 early release kept
        {1'b0,4'h0,1'b1,1'b0,4'h5,5'd2},   // R2 failure pulls pin low
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd3},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd3},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd3},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd3},
        {1'b0,4'h0,1'b0,1'b1,4'h0,5'd3},   // R3 release at E+L+1
        {1'b0,4'h0,1'b1,1'b0,4'h0,5'd2},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd5},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd5},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd5},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd5},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd5},   // R5 expired, still low
        {1'b1,4'h5,1'b0,1'b0,4'h5,5'd5},
        {1'b0,4'h0,1'b0,1'b1,4'h0,5'd5},   // R5 high at W+1
        {1'b1,4'h5,1'b0,1'b1,4'h5,5'd6},
        {1'b0,4'h0,1'b1,1'b0,4'h5,5'd4},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd4},
        {1'b0,4'h0,1'b1,1'b0,4'h5,5'd4},   // R4 second failure reloads
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd4},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd4},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd4},   // R4 old deadline passed, still low
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd4},
        {1'b0,4'h0,1'b0,1'b1,4'h0,5'd4},
        {1'b1,4'hA,1'b0,1'b0,4'hA,5'd7},   // R7 forcing
        {1'b1,4'h5,1'b0,1'b0,4'hA,5'd11},  // R11 release key ignored in forcing
        {1'b1,4'h3,1'b0,1'b0,4'hA,5'd11},
        {1'b1,4'h0,1'b0,1'b1,4'h0,5'd9},   // R9 leave forcing, no failure
        {1'b0,4'h0,1'b1,1'b0,4'h0,5'd2},
        {1'b1,4'hA,1'b0,1'b0,4'h0,5'd8},   // R8 test key while low
        {1'b1,4'h5,1'b0,1'b0,4'h5,5'd8},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd8},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd8},
        {1'b0,4'h0,1'b0,1'b1,4'h0,5'd8},
        {1'b1,4'hA,1'b0,1'b0,4'hA,5'd7},
        {1'b0,4'h0,1'b1,1'b0,4'hA,5'd10},  // R10 failure in forcing
        {1'b0,4'h0,1'b0,1'b0,4'hA,5'd10},
        {1'b0,4'h0,1'b0,1'b0,4'hA,5'd10},
        {1'b0,4'h0,1'b0,1'b0,4'hA,5'd10},
        {1'b0,4'h0,1'b0,1'b0,4'hA,5'd10},
        {1'b0,4'h0,1'b0,1'b0,4'hA,5'd10},
        {1'b1,4'h0,1'b0,1'b0,4'h0,5'd10},  // R10 exit at X, pin stays low
        {1'b1,4'h5,1'b0,1'b0,4'h5,5'd10},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd10},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd10},
        {1'b0,4'h0,1'b0,1'b0,4'h5,5'd10},
        {1'b0,4'h0,1'b0,1'b1,4'h0,5'd10},  // R10 high at X+L+1
        {1'b1,4'h5,1'b0,1'b1,4'h5,5'd12},
        {1'b1,4'h0,1'b0,1'b1,4'h0,5'd12},  // R12 cancel release
        {1'b0,4'h0,1'b1,1'b0,4'h0,5'd12},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd12},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd12},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd12},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd12},
        {1'b0,4'h0,1'b0,1'b0,4'h0,5'd12},  // R12 no pending, stays low
        {1'b1,4'h5,1'b0,1'b0,4'h5,5'd5},
        {1'b0,4'h0,1'b0,1'b1,4'h0,5'd5},
        {1'b1,4'hF,1'b0,1'b1,4'h0,5'd11},  // R11 illegal key
        {1'b1,4'h5,1'b0,1'b1,4'h5,5'd6},
        {1'b1,4'h9,1'b0,1'b1,4'h5,5'd11},
        {1'b1,4'h0,1'b0,1'b1,4'h0,5'd12}
    };

    task automatic check(input logic exp_pin, input logic [3:0] exp_key, input int req, input int step);
        total++;
        if (pin_n !== exp_pin || pin_ok !== exp_pin || rdata !== exp_key) begin
            bad++;
            $display("FAIL R%0d step %0d: pin=%b ok=%b key=%h expected pin=%b ok=%b key=%h",
                     req, step, pin_n, pin_ok, rdata, exp_pin, exp_pin, exp_key);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b1, 4'h0, 1, -1);              // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            we    = VEC[i][15];
            wdata = VEC[i][14:11];
            fail  = VEC[i][10];
            @(posedge clk);
            #1;
            check(VEC[i][9], VEC[i][8:5], int'(VEC[i][4:0]), i);
        end
        // directed: reset in the middle of a failure (R1)
        @(negedge clk);
        we = 1'b1; wdata = 4'h5; fail = 1'b1;
        @(posedge clk);
        #1;
        check(1'b0, 4'h5, 2, 100);
        @(negedge clk);
        we = 1'b0; fail = 1'b0;
        rst_n = 1'b0;
        #1;
        check(1'b1, 4'h0, 1, 101);             // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b1;
        // directed: failure and test key in the same cycle (R8)
        @(negedge clk);
        we = 1'b1; wdata = 4'hA; fail = 1'b1;
        @(posedge clk);
        #1;
        check(1'b0, 4'hA, 8, 102);             // pin high at that edge: key taken
        @(negedge clk);
        we = 1'b1; wdata = 4'h0; fail = 1'b0;
        @(posedge clk);
        #1;
        check(1'b0, 4'h0, 10, 103);            // R10 failure remembered on exit
        @(negedge clk);
        we = 1'b0;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule